// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates 48-bit virtual addresses into physical addresses by walking a four-level radix tree of page tables held in memory. A requester presents a 64-bit virtual address, a read/write flag and a two-bit ring number. The walker returns either a physical address with the page's effective permission flags or a fault with a cause code. The physical frame of the top-level table comes from a root frame input. Each level has 512 eight-byte entries and uses nine bits of the virtual address. Entries at the second and third levels may end the walk early to map a 1 GB or a 2 MB page.

Successful translations are kept in a small direct-mapped translation cache indexed by the 4 KB virtual page number, so a repeated request in the same page needs no memory reads. A flush input empties the cache in one cycle. The walker serves one request at a time. It uses valid/ready handshakes on the request, the response and the memory read port. Memory answers each accepted read with one response beat in some later cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: A miss walks from the top level down and makes one read per level. Each read address is {table frame, 9-bit index, 3'b000}, where the index is va[47:39], va[38:30], va[29:21] and then va[20:12]. The next table frame is taken from the entry's bits [PA_W-1:12].
- R3: A 4 KB leaf produces `rsp_pa` = {entry bits [PA_W-1:12], va[11:0]} after exactly four reads.
- R4: Entry bit 7 set at the second level ends the walk after two reads with a 1 GB page: PA = {entry[PA_W-1:30], va[29:0]}. Set at the third level, it ends the walk after three reads with a 2 MB page: PA = {entry[PA_W-1:21], va[20:0]}. Bit 7 is ignored at the top level and at the last level.
- R5: Entry bit 1 (writable) and bit 2 (user) are ANDed over every entry on the path and reported as `rsp_writable` and `rsp_user`. `rsp_dirty` is bit 6 of the leaf entry.
- R6: An entry with bit 0 (present) clear stops the walk at that level and gives fault cause 1.
- R7: Only ring 3 is user; rings 0 to 2 are supervisor. A user access to a page whose effective user flag is 0 gives cause 3, and this takes priority over cause 2.
- R8: A write to a page whose effective writable flag is 0 gives cause 2, whatever the ring.
- R9: If va[63:48] is not a copy of va[47], the request faults with cause 4. No memory read is made, and the response appears in the cycle after acceptance. `rsp_fault` is 1 exactly when the cause is nonzero.
- R10: Only fault-free walks fill the cache. A later request in the same 4 KB page needs zero reads, and its permissions are still checked against the cached flags. A different page with the same low virtual page number bits evicts the entry.
- R11: `flush` invalidates every cache entry. A flush in the same cycle as an accepted request forces that lookup to miss. A flush in the same cycle as a fill leaves the page uncached.
- R12: Only one request is in flight. `req_ready` is low while a walk or response is pending. A held response and an unaccepted memory read keep their values stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | PA_W-12 | Frame number of the top-level table |
| flush | input | 1 | Invalidate the whole translation cache |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_ring | input | 2 | Ring of the requester (3 is user) |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_writable | output | 1 | Effective writable flag |
| rsp_user | output | 1 | Effective user flag |
| rsp_dirty | output | 1 | Dirty bit of the leaf entry |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cause | output | 3 | 0 none, 1 not present, 2 read-only write, 3 supervisor page from user, 4 non-canonical |

## Verification
A flush can land in the same cycle as a cache lookup or in the same cycle as a cache fill. In both cases the flush must win. The first case is provoked by raising `flush` together with the request for a page that is already cached. The second case is provoked by the memory model: it raises `flush` in the exact cycle it returns the leaf entry of a four-read walk. Each case is judged at the ports by the read count of the next identical request: it must be four, not zero. A third identical request must then show zero reads, which proves that the cache still fills normally once the coincidence has passed.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int VA_BITS  = 48;
    localparam int PG_SHIFT = 12;
    localparam int IDX_BITS = 9;
    localparam int VPN_BITS = VA_BITS - PG_SHIFT;

    // entry bit positions
    localparam int E_PRESENT = 0;
    localparam int E_WRITE   = 1;
    localparam int E_USER    = 2;
    localparam int E_DIRTY   = 6;
    localparam int E_LARGE   = 7;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_ABSENT   = 3'd1,
        CAUSE_RDONLY   = 3'd2,
        CAUSE_PRIV     = 3'd3,
        CAUSE_NONCANON = 3'd4
    } fault_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MREQ,
        ST_MWAIT,
        ST_RESP
    } walk_st_e;

endpackage

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walker_pkg::*;
(
    input  logic       is_user,
    input  logic       is_write,
    input  logic       eff_w,
    input  logic       eff_u,
    output logic       fault,
    output logic [2:0] cause
);

    always_comb begin
        fault = 1'b0;
        cause = CAUSE_NONE;
        if (is_user && !eff_u) begin
            fault = 1'b1;
            cause = CAUSE_PRIV;
        end else if (is_write && !eff_w) begin
            fault = 1'b1;
            cause = CAUSE_RDONLY;
        end
    end

endmodule

// File: rtl/pt_tcache.sv
module pt_tcache #(
    parameter int VPN_W = 36,
    parameter int IDX_W = 3,
    parameter int DW    = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lookup_vpn,
    output logic             hit,
    output logic [DW-1:0]    hit_data,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [DW-1:0]    fill_data
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = VPN_W - IDX_W;

    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]   tag_d  [ENTRIES];
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DW-1:0]      data_d [ENTRIES];
    logic [DW-1:0]      data_q [ENTRIES];

    logic [IDX_W-1:0] l_idx, f_idx;

    assign l_idx = lookup_vpn[IDX_W-1:0];
    assign f_idx = fill_vpn[IDX_W-1:0];

    always_comb begin
        hit      = valid_q[l_idx] && (tag_q[l_idx] == lookup_vpn[VPN_W-1:IDX_W]) && !flush;
        hit_data = data_q[l_idx];
    end

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        data_d  = data_q;
        if (fill_en) begin
            valid_d[f_idx] = 1'b1;
            tag_d[f_idx]   = fill_vpn[VPN_W-1:IDX_W];
            data_d[f_idx]  = fill_data;
        end
        if (flush) begin
            valid_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
        tag_q  <= tag_d;
        data_q <= data_d;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PA_W     = 40,
    parameter int TC_IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-13:0] root_frame,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_va,
    input  logic             req_write,
    input  logic [1:0]       req_ring,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_writable,
    output logic             rsp_user,
    output logic             rsp_dirty,
    output logic             rsp_fault,
    output logic [2:0]       rsp_cause
);

    localparam int FRAME_W = PA_W - PG_SHIFT;
    localparam int TC_DW   = FRAME_W + 3;

    typedef struct packed {
        walk_st_e           st;
        logic [1:0]         lvl;
        logic [VA_BITS-1:0] va;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] tbl;
        logic               ew;
        logic               eu;
        logic               dirty;
        logic [FRAME_W-1:0] frame;
        logic               fault;
        logic [2:0]         cause;
    } walk_t;

    walk_t r_d, r_q;

    function automatic logic [IDX_BITS-1:0] lvl_index(input logic [VA_BITS-1:0] va,
                                                      input logic [1:0] lvl);
        case (lvl)
            2'd3:    return va[47:39];
            2'd2:    return va[38:30];
            2'd1:    return va[29:21];
            default: return va[20:12];
        endcase
    endfunction

    // request-side decode
    logic canon, req_user;
    assign canon    = (&req_va[63:47]) || !(|req_va[63:47]);
    assign req_user = (req_ring == 2'd3);

    // translation cache
    logic             tc_hit;
    logic [TC_DW-1:0] tc_hit_data;
    logic             tc_fill;
    logic [TC_DW-1:0] tc_fill_data;

    // walk-side decode
    logic [63:0]        pte;
    logic               ew_n, eu_n, leaf;
    logic [FRAME_W-1:0] leaf_frame;
    logic               hit_fault, walk_fault;
    logic [2:0]         hit_cause, walk_cause;

    assign pte  = mem_rsp_data;
    assign ew_n = r_q.ew & pte[E_WRITE];
    assign eu_n = r_q.eu & pte[E_USER];
    assign leaf = (r_q.lvl == 2'd0) ||
                  (pte[E_LARGE] && ((r_q.lvl == 2'd1) || (r_q.lvl == 2'd2)));

    always_comb begin
        case (r_q.lvl)
            2'd1:    leaf_frame = {pte[PA_W-1:21], r_q.va[20:12]};
            2'd2:    leaf_frame = {pte[PA_W-1:30], r_q.va[29:12]};
            default: leaf_frame = pte[PA_W-1:12];
        endcase
    end

    pt_perm_check hit_chk_i (
        .is_user  (req_user),
        .is_write (req_write),
        .eff_w    (tc_hit_data[2]),
        .eff_u    (tc_hit_data[1]),
        .fault    (hit_fault),
        .cause    (hit_cause)
    );

    pt_perm_check walk_chk_i (
        .is_user  (r_q.usr),
        .is_write (r_q.wr),
        .eff_w    (ew_n),
        .eff_u    (eu_n),
        .fault    (walk_fault),
        .cause    (walk_cause)
    );

    assign tc_fill = (r_q.st == ST_MWAIT) && mem_rsp_valid && pte[E_PRESENT] &&
                     leaf && !walk_fault;
    assign tc_fill_data = {leaf_frame, ew_n, eu_n, pte[E_DIRTY]};

    pt_tcache #(
        .VPN_W (VPN_BITS),
        .IDX_W (TC_IDX_W),
        .DW    (TC_DW)
    ) tcache_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lookup_vpn (req_va[VA_BITS-1:PG_SHIFT]),
        .hit        (tc_hit),
        .hit_data   (tc_hit_data),
        .fill_en    (tc_fill),
        .fill_vpn   (r_q.va[VA_BITS-1:PG_SHIFT]),
        .fill_data  (tc_fill_data)
    );

    // next-state computation
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_va[VA_BITS-1:0];
                    r_d.wr    = req_write;
                    r_d.usr   = req_user;
                    r_d.tbl   = root_frame;
                    r_d.lvl   = 2'd3;
                    r_d.ew    = 1'b1;
                    r_d.eu    = 1'b1;
                    r_d.dirty = 1'b0;
                    r_d.fault = 1'b0;
                    r_d.cause = CAUSE_NONE;
                    if (!canon) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_NONCANON;
                        r_d.st    = ST_RESP;
                    end else if (tc_hit) begin
                        r_d.frame = tc_hit_data[TC_DW-1:3];
                        r_d.ew    = tc_hit_data[2];
                        r_d.eu    = tc_hit_data[1];
                        r_d.dirty = tc_hit_data[0];
                        r_d.fault = hit_fault;
                        r_d.cause = hit_cause;
                        r_d.st    = ST_RESP;
                    end else begin
                        r_d.st = ST_MREQ;
                    end
                end
            end
            ST_MREQ: begin
                if (mem_req_ready) begin
                    r_d.st = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte[E_PRESENT]) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_ABSENT;
                        r_d.st    = ST_RESP;
                    end else begin
                        r_d.ew = ew_n;
                        r_d.eu = eu_n;
                        if (leaf) begin
                            r_d.frame = leaf_frame;
                            r_d.dirty = pte[E_DIRTY];
                            r_d.fault = walk_fault;
                            r_d.cause = walk_cause;
                            r_d.st    = ST_RESP;
                        end else begin
                            r_d.tbl = pte[PA_W-1:12];
                            r_d.lvl = r_q.lvl - 2'd1;
                            r_d.st  = ST_MREQ;
                        end
                    end
                end
            end
            default: begin
                if (rsp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_MREQ);
    assign mem_req_addr  = {r_q.tbl, lvl_index(r_q.va, r_q.lvl), 3'b000};
    assign rsp_valid     = (r_q.st == ST_RESP);
    assign rsp_pa        = {r_q.frame, r_q.va[PG_SHIFT-1:0]};
    assign rsp_writable  = r_q.ew;
    assign rsp_user      = r_q.eu;
    assign rsp_dirty     = r_q.dirty;
    assign rsp_fault     = r_q.fault;
    assign rsp_cause     = r_q.cause;

    logic unused_bits;
    assign unused_bits = ^{pte[63:PA_W], pte[11:8], pte[5:3]};

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [63:0]     req_va,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_fault,
    input logic [2:0]      rsp_cause
);

    logic       canon;
    logic [2:0] reads_q;

    assign canon = (&req_va[63:47]) || !(|req_va[63:47]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_q <= '0;
        end else if (req_valid && req_ready) begin
            reads_q <= '0;
        end else if (mem_req_valid && mem_req_ready && reads_q != 3'd7) begin
            reads_q <= reads_q + 3'd1;
        end
    end

    // R9
    noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !canon) |=> (rsp_valid && rsp_fault && rsp_cause == 3'd4));

    // R9
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

    // R2
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reads_q <= 3'd4);

    // R2
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R12
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_cause)));

    // R12
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(rsp_valid || mem_req_valid));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_pa        (rsp_pa),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

    localparam int PA_W = 40;

    localparam logic [63:0] FP = 64'h01;
    localparam logic [63:0] FW = 64'h02;
    localparam logic [63:0] FU = 64'h04;
    localparam logic [63:0] FD = 64'h40;
    localparam logic [63:0] FL = 64'h80;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PA_W-13:0] root_frame = 28'h100;
    logic            flush;
    logic            flush_drv = 1'b0;
    logic            flush_m = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_va = '0;
    logic            req_write = 1'b0;
    logic [1:0]      req_ring = 2'd0;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b1;
    logic [PA_W-1:0] rsp_pa;
    logic            rsp_writable, rsp_user, rsp_dirty, rsp_fault;
    logic [2:0]      rsp_cause;

    assign flush = flush_drv | flush_m;

    always #10 clk = ~clk;

    pt_walker #(.PA_W(PA_W), .TC_IDX_W(3)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_frame    (root_frame),
        .flush         (flush),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_write     (req_write),
        .req_ring      (req_ring),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_pa        (rsp_pa),
        .rsp_writable  (rsp_writable),
        .rsp_user      (rsp_user),
        .rsp_dirty     (rsp_dirty),
        .rsp_fault     (rsp_fault),
        .rsp_cause     (rsp_cause)
    );

    // ---------------- memory model ----------------
    logic [63:0] pt_mem [logic [PA_W-1:0]];
    logic [31:0] cyc = '0;
    int          reads = 0;
    logic        arm_fill_flush = 1'b0;

    function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
        if (pt_mem.exists(a)) return pt_mem[a];
        return 64'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= 1'b0;
            flush_m       <= 1'b0;
            reads         <= 0;
        end else begin
            cyc           <= cyc + 1;
            mem_req_ready <= (cyc[1:0] != 2'b01);
            mem_rsp_valid <= 1'b0;
            flush_m       <= 1'b0;
            if (req_valid && req_ready) reads <= 0;
            if (mem_req_valid && mem_req_ready) begin
                reads         <= reads + 1;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(mem_req_addr);
                if (arm_fill_flush && reads == 3) flush_m <= 1'b1;
            end
        end
    end

    task automatic set_pte(input logic [27:0] tbl, input int idx, input logic [63:0] v);
        logic [8:0] i9;
        i9 = idx[8:0];
        pt_mem[{tbl, i9, 3'b000}] = v;
    endtask

    function automatic logic [63:0] pte(input logic [27:0] frame, input logic [63:0] fl);
        return ({36'h0, frame} << 12) | fl;
    endfunction

    function automatic logic [63:0] mkva(input int l3, input int l2, input int l1,
                                         input int l0, input int off);
        return (64'(l3) << 39) | (64'(l2) << 30) | (64'(l1) << 21) |
               (64'(l0) << 12) | 64'(off);
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct {
        logic            fault;
        logic [2:0]      cause;
        logic [PA_W-1:0] pa;
        logic [2:0]      flags;
        int              nreads;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12", "unexpected response", 64'(rsp_cause), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_fault == e.fault && rsp_cause == e.cause, e.tag, "cause",
                      64'(rsp_cause), 64'(e.cause));
                check(reads == e.nreads, e.tag, "memory reads", 64'(reads), 64'(e.nreads));
                if (!e.fault) begin
                    check(rsp_pa == e.pa, e.tag, "physical address", 64'(rsp_pa), 64'(e.pa));
                    check({rsp_writable, rsp_user, rsp_dirty} == e.flags, e.tag, "flags w/u/d",
                          64'({rsp_writable, rsp_user, rsp_dirty}), 64'(e.flags));
                end
            end
        end
    end

    task automatic send(input logic [63:0] va, input logic wr, input logic [1:0] ring,
                        input logic with_flush, input logic flt, input logic [2:0] cause,
                        input logic [PA_W-1:0] pa, input logic [2:0] flags,
                        input int nreads, input string tag);
        exp_t e;
        e.fault = flt; e.cause = cause; e.pa = pa; e.flags = flags;
        e.nreads = nreads; e.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_va    = va;
        req_write = wr;
        req_ring  = ring;
        flush_drv = with_flush;
        @(negedge clk);
        req_valid = 1'b0;
        flush_drv = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush_drv = 1'b1;
        @(negedge clk);
        flush_drv = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    // ---------------- stimulus ----------------
    logic [63:0] va1, va5, va6;

    initial begin
        // page tables
        set_pte(28'h100, 1, pte(28'h200, FP|FW|FU));
        set_pte(28'h100, 3, pte(28'h210, FP|FW|FU|FL));
        set_pte(28'h200, 2, pte(28'h300, FP|FW|FU));
        set_pte(28'h200, 9, pte(28'h40155, FP|FW|FU|FL|FD));
        set_pte(28'h300, 3, pte(28'h400, FP|FW|FU));
        set_pte(28'h300, 6, pte(28'h410, FP));
        set_pte(28'h300, 7, pte(28'h122AB, FP|FW|FU|FL));
        set_pte(28'h400, 4, pte(28'h5555, FP|FW|FU|FD));
        set_pte(28'h400, 5, pte(28'h5556, FP|FU));
        set_pte(28'h400, 12, pte(28'h5600, FP|FW|FU));
        set_pte(28'h410, 0, pte(28'h6000, FP|FW|FU));
        set_pte(28'h210, 0, pte(28'h310, FP|FW|FU));
        set_pte(28'h310, 0, pte(28'h420, FP|FW|FU));
        set_pte(28'h420, 0, pte(28'h7777, FP|FW|FU|FL));

        va1 = mkva(1, 2, 3, 4, 12'h123);
        va5 = mkva(1, 2, 3, 5, 12'h010);
        va6 = mkva(1, 2, 6, 0, 12'h020);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'h1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'h0);

        // R2 R3: full 4 KB walk
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 4, "R3");
        // R10: hit in same page
        send(mkva(1, 2, 3, 4, 12'hABC), 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555ABC, 3'b111, 0, "R10");
        // R8: user write to read-only leaf
        send(va5, 1'b1, 2'd3, 1'b0, 1'b1, 3'd2, '0, 3'b000, 4, "R8");
        // R5: flags; faulted walk was not cached
        send(va5, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5556010, 3'b010, 4, "R5");
        // R10: permission still checked on hit
        send(va5, 1'b1, 2'd0, 1'b0, 1'b1, 3'd2, '0, 3'b000, 0, "R10");
        // R7: user to supervisor page
        send(va6, 1'b0, 2'd3, 1'b0, 1'b1, 3'd3, '0, 3'b000, 4, "R7");
        // R5: AND over path
        send(va6, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 40'h6000020, 3'b000, 4, "R5");
        // R7: cause 3 beats cause 2
        send(va6, 1'b1, 2'd3, 1'b0, 1'b1, 3'd3, '0, 3'b000, 0, "R7");
        // R7: ring 2 is supervisor
        send(va6, 1'b0, 2'd2, 1'b0, 1'b0, 3'd0, 40'h6000020, 3'b000, 0, "R7");
        // R8: supervisor write to read-only
        send(va6, 1'b1, 2'd1, 1'b0, 1'b1, 3'd2, '0, 3'b000, 0, "R8");
        // R4: 2 MB page
        send(mkva(1, 2, 7, 9'h1AB, 12'h0FF), 1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 40'h123AB0FF, 3'b110, 3, "R4");
        // R4: 1 GB page
        send(mkva(1, 9, 9'h55, 9'h66, 12'h777), 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h4AA66777, 3'b111, 2, "R4");
        // R4: large bit ignored at top and last level
        send(mkva(3, 0, 0, 0, 12'h005), 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h7777005, 3'b110, 4, "R4");
        // R6: not present at second and top level
        send(mkva(1, 11, 0, 0, 0), 1'b0, 2'd0, 1'b0, 1'b1, 3'd1, '0, 3'b000, 2, "R6");
        send(mkva(5, 0, 0, 0, 0), 1'b0, 2'd0, 1'b0, 1'b1, 3'd1, '0, 3'b000, 1, "R6");
        // R9: non-canonical addresses, canonical high half passes
        send(64'h0000_8000_0000_0000, 1'b0, 2'd0, 1'b0, 1'b1, 3'd4, '0, 3'b000, 0, "R9");
        send(64'h0001_0000_0000_0000, 1'b0, 2'd0, 1'b0, 1'b1, 3'd4, '0, 3'b000, 0, "R9");
        send(64'hFFFF_8000_0000_0000, 1'b0, 2'd0, 1'b0, 1'b1, 3'd1, '0, 3'b000, 1, "R9");
        // R10: eviction by same low index
        send(mkva(1, 2, 3, 12, 0), 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5600000, 3'b110, 4, "R10");
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 4, "R10");
        // R11: plain flush
        pulse_flush();
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 4, "R11");
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 0, "R11");
        // R11: flush coincident with lookup
        send(va1, 1'b0, 2'd3, 1'b1, 1'b0, 3'd0, 40'h5555123, 3'b111, 4, "R11");
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 0, "R11");
        // R11: flush coincident with fill
        pulse_flush();
        arm_fill_flush = 1'b1;
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 4, "R11");
        arm_fill_flush = 1'b0;
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 4, "R11");
        send(va1, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 40'h5555123, 3'b111, 0, "R11");
        // R12: response held while rsp_ready low
        rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va1; req_write = 1'b0; req_ring = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b1, "R12", "response held", 64'(rsp_valid), 64'h1);
        check(req_ready == 1'b0, "R12", "no accept while pending", 64'(req_ready), 64'h0);
        check(rsp_pa == 40'h5555123, "R12", "held address", 64'(rsp_pa), 64'h5555123);
        exp_q.push_back('{1'b0, 3'd0, 40'h5555123, 3'b111, 0, "R12"});
        rsp_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R12", "idle after handshake", 64'(req_ready), 64'h1);

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule